// File: doc/BRIEF.md
# Atomic Lock and Semaphore Unit

This block sits on the memory side of a shared-memory system. It holds a small bank of synchronisation words and serves several requesters through a single arbitrated port. Each accepted operation is an indivisible read-modify-write. The read of the addressed word, the decision on the new value and the write-back all happen in the one cycle in which the request is granted. No other requester can reach the port in that cycle, so no other requester can get between the read and the write.

Requesters use it in two ways:
- **Locks.** Test-and-set acquires a lock and a plain release store frees it. A side-effect-free read lets software spin on a cached-style test before it tries the atomic set.
- **Counting semaphores.** An initialise operation loads the count N. A conditional decrement ("wait") succeeds only while the count is nonzero. An increment ("signal") returns a permit. A general fetch-and-add is also available. With N = 1 a semaphore behaves as a lock.

Every response carries the value the word held before the operation, a success flag and the index of the requester it belongs to.

Top module: `atomic_sync_unit`

## Requirements
- R1: In any cycle at most one `grant` bit is high. A grant bit is high only for a requester whose `reqValid` bit is high. When any `reqValid` bit is high, exactly one grant is issued in that same cycle.
- R2: Arbitration is round-robin. Search order starts at the requester after the most recently granted one. After reset, requester 0 has the highest priority.
- R3: `rspValid` goes high exactly one cycle after a grant, and is low in every cycle that does not follow a grant. With it, `rspId` gives the granted requester index and `rspOld` gives the word value from before the operation.
- R4: Op code 1 (test-and-set) leaves 1 in the word. `rspOk` is 1 exactly when the prior value was 0, which means the lock was acquired.
- R5: Op code 2 (release) stores 0 in the word and returns `rspOk` = 1.
- R6: Op code 3 (fetch-and-add) stores the prior value plus the requester's operand, modulo 2^DATA_W, and returns `rspOk` = 1.
- R7: Op code 4 (wait) behaves as follows:
  - When the prior value is nonzero, it stores the value minus 1 and returns `rspOk` = 1.
  - When the prior value is 0, it leaves the word at 0 and returns `rspOk` = 0. It never wraps.
- R8: Op code 5 (signal) stores the prior value plus 1 and returns `rspOk` = 1. At the all-ones value it leaves the word unchanged and returns `rspOk` = 0.
- R9: Op code 6 (initialise) stores the operand as the new count and returns `rspOk` = 1.
- R10: Op codes 0 (read) and 7 (spare) leave the word unchanged and return `rspOk` = 1.
- R11: Operations on the same word in consecutive cycles are serialised. Each one sees the value left by the one before.
- R12: After reset every word reads 0 and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | One request strobe per requester |
| reqOp | input | NUM_REQ*3 | Op code per requester, slice r at [3r+2:3r] |
| reqAddr | input | NUM_REQ*ADDR_W | Word index per requester |
| reqData | input | NUM_REQ*DATA_W | Operand per requester (addend or initial count) |
| grant | output | NUM_REQ | One-hot grant, combinational from `reqValid` |
| rspValid | output | 1 | Response strobe, one cycle after a grant |
| rspId | output | IDX_W | Index of the requester being answered |
| rspOld | output | DATA_W | Word value before the operation |
| rspOk | output | 1 | Success flag of the operation |

## Verification
The bench goes after these corner cases:
- **Lock contention.** All requesters issue test-and-set on the same lock in the same cycle. A design that broke atomicity, or arbitrated unfairly, would report two successful acquisitions or starve a requester.
- **Boundary values.** Waits at a zero count would wrap to all ones if the underflow guard were missing. Signals at the all-ones value would wrap to zero if saturation were missing. A fetch-and-add past the top must wrap, and a design that clamped it would return the wrong new value.
- **Back-to-back operations on one word.** These would expose a design that returned a stale value, or lost an update across adjacent cycles.
- **Random mix.** A long random run with colliding addresses checks every cycle against a behavioural model. Any mistake in the round-robin pointer or in the one-cycle response timing shows up as a mismatch in `grant` or `rspId`.

// File: rtl/sync_unit_pkg.sv
package sync_unit_pkg;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_TAS     = 3'd1,
    OP_RELEASE = 3'd2,
    OP_FADD    = 3'd3,
    OP_WAIT    = 3'd4,
    OP_SIGNAL  = 3'd5,
    OP_INIT    = 3'd6,
    OP_SPARE   = 3'd7
  } atomOp_e;

  localparam int OP_W = 3;

  typedef enum logic [2:0] {
    SEL_KEEP,
    SEL_ONE,
    SEL_ZERO,
    SEL_ADD,
    SEL_DEC,
    SEL_INC,
    SEL_LOAD
  } newSel_e;

  typedef struct packed {
    logic    doOp;
    logic    wrEn;
    newSel_e newSel;
    logic    okFlag;
  } ctrlStrobe_t;

endpackage

// File: rtl/sync_rr_arbiter.sv
module sync_rr_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqValid,
  output logic [NUM_REQ-1:0] grant,
  output logic [IDX_W-1:0]   grantIdx,
  output logic               grantAny
);

  logic [IDX_W-1:0] lastIdx;

  always_comb begin
    int cand;
    grant    = '0;
    grantIdx = '0;
    grantAny = 1'b0;
    for (int off = 1; off <= NUM_REQ; off++) begin
      cand = (int'(lastIdx) + off) % NUM_REQ;
      if (!grantAny && reqValid[cand]) begin
        grantAny    = 1'b1;
        grant[cand] = 1'b1;
        grantIdx    = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIdx <= IDX_W'(NUM_REQ - 1);
    end else if (grantAny) begin
      lastIdx <= grantIdx;
    end
  end

endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import sync_unit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grantAny,
  input  logic [IDX_W-1:0]  grantIdx,
  input  atomOp_e           selOp,
  input  logic [DATA_W-1:0] oldVal,
  output ctrlStrobe_t       strobe,
  output logic              rspValid,
  output logic [IDX_W-1:0]  rspId
);

  localparam logic [DATA_W-1:0] MAX_VAL = '1;

  always_comb begin
    strobe.doOp   = grantAny;
    strobe.wrEn   = 1'b0;
    strobe.newSel = SEL_KEEP;
    strobe.okFlag = 1'b1;
    unique case (selOp)
      OP_TAS: begin
        strobe.wrEn   = 1'b1;
        strobe.newSel = SEL_ONE;
        strobe.okFlag = (oldVal == '0);
      end
      OP_RELEASE: begin
        strobe.wrEn   = 1'b1;
        strobe.newSel = SEL_ZERO;
      end
      OP_FADD: begin
        strobe.wrEn   = 1'b1;
        strobe.newSel = SEL_ADD;
      end
      OP_WAIT: begin
        strobe.wrEn   = (oldVal != '0);
        strobe.newSel = SEL_DEC;
        strobe.okFlag = (oldVal != '0);
      end
      OP_SIGNAL: begin
        strobe.wrEn   = (oldVal != MAX_VAL);
        strobe.newSel = SEL_INC;
        strobe.okFlag = (oldVal != MAX_VAL);
      end
      OP_INIT: begin
        strobe.wrEn   = 1'b1;
        strobe.newSel = SEL_LOAD;
      end
      default: begin
        strobe.wrEn   = 1'b0;
        strobe.newSel = SEL_KEEP;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspId    <= '0;
    end else begin
      rspValid <= grantAny;
      if (grantAny) rspId <= grantIdx;
    end
  end

endmodule

// File: rtl/sync_datapath.sv
module sync_datapath
  import sync_unit_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] selAddr,
  input  logic [DATA_W-1:0] selData,
  output logic [DATA_W-1:0] oldVal,
  output logic [DATA_W-1:0] rspOld,
  output logic              rspOk
);

  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] newVal;

  assign oldVal = words[selAddr];

  always_comb begin
    unique case (strobe.newSel)
      SEL_ONE:  newVal = DATA_W'(1);
      SEL_ZERO: newVal = '0;
      SEL_ADD:  newVal = oldVal + selData;
      SEL_DEC:  newVal = oldVal - DATA_W'(1);
      SEL_INC:  newVal = oldVal + DATA_W'(1);
      SEL_LOAD: newVal = selData;
      default:  newVal = oldVal;
    endcase
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        words[w] <= '0;
      end else if (strobe.doOp && strobe.wrEn && selAddr == ADDR_W'(w)) begin
        words[w] <= newVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspOld <= '0;
      rspOk  <= 1'b0;
    end else if (strobe.doOp) begin
      rspOld <= oldVal;
      rspOk  <= strobe.okFlag;
    end
  end

endmodule

// File: rtl/atomic_sync_unit.sv
module atomic_sync_unit
  import sync_unit_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [NUM_REQ*OP_W-1:0]   reqOp,
  input  logic [NUM_REQ*ADDR_W-1:0] reqAddr,
  input  logic [NUM_REQ*DATA_W-1:0] reqData,
  output logic [NUM_REQ-1:0]        grant,
  output logic                      rspValid,
  output logic [IDX_W-1:0]          rspId,
  output logic [DATA_W-1:0]         rspOld,
  output logic                      rspOk
);

  logic [IDX_W-1:0]  grantIdx;
  logic              grantAny;
  atomOp_e           selOp;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  logic [DATA_W-1:0] oldVal;
  ctrlStrobe_t       strobe;

  assign selOp   = atomOp_e'(reqOp[grantIdx*OP_W +: OP_W]);
  assign selAddr = reqAddr[grantIdx*ADDR_W +: ADDR_W];
  assign selData = reqData[grantIdx*DATA_W +: DATA_W];

  sync_rr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .grant(grant), .grantIdx(grantIdx), .grantAny(grantAny)
  );

  sync_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .grantAny(grantAny), .grantIdx(grantIdx),
    .selOp(selOp), .oldVal(oldVal), .strobe(strobe),
    .rspValid(rspValid), .rspId(rspId)
  );

  sync_datapath #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selAddr(selAddr),
    .selData(selData), .oldVal(oldVal), .rspOld(rspOld), .rspOk(rspOk)
  );

endmodule

// File: rtl/sync_unit_checker.sv
module sync_unit_checker
  import sync_unit_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int IDX_W   = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_REQ-1:0]        reqValid,
  input logic [NUM_REQ*OP_W-1:0]   reqOp,
  input logic [NUM_REQ-1:0]        grant,
  input logic                      rspValid,
  input logic [IDX_W-1:0]          rspId,
  input logic [DATA_W-1:0]         rspOld,
  input logic                      rspOk
);

  logic [IDX_W-1:0] chkIdx;
  logic [OP_W-1:0]  chkOp;

  always_comb begin
    chkIdx = '0;
    chkOp  = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (grant[r]) begin
        chkIdx = IDX_W'(r);
        chkOp  = reqOp[r*OP_W +: OP_W];
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R1
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~reqValid) == '0); // R1
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |-> (|grant)); // R1
  AST_RSP_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |=> (rspValid && rspId == $past(chkIdx))); // R3
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !(|grant) |=> !rspValid); // R3
  AST_TAS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((|grant) && chkOp == OP_W'(OP_TAS)) |=> (rspOk == (rspOld == '0))); // R4
  AST_WAIT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((|grant) && chkOp == OP_W'(OP_WAIT)) |=> (rspOk == (rspOld != '0))); // R7

endmodule

bind atomic_sync_unit sync_unit_checker #(
  .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .grant(grant),
  .rspValid(rspValid), .rspId(rspId), .rspOld(rspOld), .rspOk(rspOk)
);

// File: tb/test_atomic_sync_unit.sv
module test_atomic_sync_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int NW = 8;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int IW = 2;
  localparam int MAXV = (1 << DW) - 1;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NR-1:0]     reqValid;
  logic [NR*3-1:0]   reqOp;
  logic [NR*AW-1:0]  reqAddr;
  logic [NR*DW-1:0]  reqData;
  logic [NR-1:0]     grant;
  logic              rspValid;
  logic [IW-1:0]     rspId;
  logic [DW-1:0]     rspOld;
  logic              rspOk;

  atomic_sync_unit #(.NUM_REQ(NR), .NUM_WORDS(NW), .DATA_W(DW)) i_atomic_sync_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .grant(grant), .rspValid(rspValid), .rspId(rspId),
    .rspOld(rspOld), .rspOk(rspOk)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int testCount = 0;
  int failCount = 0;
  string scenTag = "";

  // behavioural reference state
  int mWord[NW];
  int mLast;
  bit expValid;
  int expId, expOld, expOp;
  bit expOk;

  task automatic check(bit cond, string tag, int got, int exp);
    testCount++;
    if (!cond) begin
      failCount++;
      $display("FAIL %s [%s] got %0h expected %0h", tag, scenTag, got, exp);
    end
  endtask

  function automatic string opTag(int op);
    case (op)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  task automatic setReq(int r, int op, int addr, int data);
    reqValid[r] = 1'b1;
    reqOp[r*3 +: 3] = op[2:0];
    reqAddr[r*AW +: AW] = addr[AW-1:0];
    reqData[r*DW +: DW] = data[DW-1:0];
  endtask

  task automatic beginCycle();
    @(negedge clk);
    reqValid = '0;
    reqOp = '0;
    reqAddr = '0;
    reqData = '0;
  endtask

  // compares this cycle's grant and last cycle's response, then advances the model
  task automatic endCycle();
    int pick;
    logic [NR-1:0] expG;
    int a, op, d, old, nv;
    bit ok;
    #1;
    if (expValid) begin
      check(rspValid === 1'b1 && int'(rspId) == expId, "R3", int'(rspId), expId);
      check(int'(rspOld) == expOld, opTag(expOp), int'(rspOld), expOld);
      check(rspOk === expOk, opTag(expOp), int'(rspOk), int'(expOk));
    end else begin
      check(rspValid === 1'b0, "R3", int'(rspValid), 0);
    end
    pick = -1;
    for (int off = 1; off <= NR; off++) begin
      int c;
      c = (mLast + off) % NR;
      if (pick < 0 && reqValid[c]) pick = c;
    end
    expG = '0;
    if (pick >= 0) expG[pick] = 1'b1;
    check(grant === expG, "R2", int'(grant), int'(expG));
    check($onehot0(grant) && ((grant & ~reqValid) == '0), "R1", int'(grant), int'(expG));
    expValid = (pick >= 0);
    if (pick >= 0) begin
      mLast = pick;
      op = int'(reqOp[pick*3 +: 3]);
      a  = int'(reqAddr[pick*AW +: AW]);
      d  = int'(reqData[pick*DW +: DW]);
      old = mWord[a];
      nv = old;
      ok = 1'b1;
      case (op)
        1: begin ok = (old == 0); nv = 1; end
        2: nv = 0;
        3: nv = (old + d) % (MAXV + 1);
        4: begin ok = (old != 0); if (old != 0) nv = old - 1; end
        5: begin ok = (old != MAXV); if (old != MAXV) nv = old + 1; end
        6: nv = d;
        default: nv = old;
      endcase
      mWord[a] = nv;
      expId = pick;
      expOld = old;
      expOk = ok;
      expOp = op;
    end
  endtask

  task automatic single(int r, int op, int addr, int data);
    beginCycle();
    setReq(r, op, addr, data);
    endCycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NW; i++) mWord[i] = 0;
    mLast = NR - 1;
    expValid = 1'b0;
    expId = 0; expOld = 0; expOp = 0; expOk = 1'b0;
    rstN = 1'b0;
    reqValid = '0; reqOp = '0; reqAddr = '0; reqData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R12: idle after reset, then every word reads zero
    scenTag = "R12 reset";
    #1;
    check(rspValid === 1'b0, "R12", int'(rspValid), 0);
    check(grant === '0, "R12", int'(grant), 0);
    for (int w = 0; w < NW; w++) single(0, 0, w, 0);

    // R4 R5 R11: acquire, failed retry on same word next cycle, release
    scenTag = "R11 lock";
    single(1, 1, 0, 0);
    single(1, 1, 0, 0);
    single(2, 2, 0, 0);
    single(3, 1, 0, 0);
    single(3, 0, 0, 0);

    // R2: all requesters race for one lock, repeated so the pointer rotates
    scenTag = "R2 contention";
    for (int k = 0; k < 6; k++) begin
      beginCycle();
      for (int r = 0; r < NR; r++) setReq(r, 1, 1, 0);
      endCycle();
    end
    single(0, 2, 1, 0);

    // R9 R7: semaphore with two permits, three waiters, then a signal
    scenTag = "R7 semaphore";
    single(0, 6, 2, 2);
    single(1, 4, 2, 0);
    single(2, 4, 2, 0);
    single(3, 4, 2, 0);
    single(3, 4, 2, 0);
    single(1, 5, 2, 0);
    single(3, 4, 2, 0);
    single(0, 0, 2, 0);

    // R7: wait on a zero count never wraps
    scenTag = "R7 underflow";
    single(2, 4, 3, 0);
    single(2, 0, 3, 0);

    // R8: signal saturates at all ones
    scenTag = "R8 saturate";
    single(1, 6, 4, 254);
    single(1, 5, 4, 0);
    single(1, 5, 4, 0);
    single(1, 0, 4, 0);

    // R6 R10: fetch-and-add wraps, spare code behaves as a read
    scenTag = "R6 wrap";
    single(0, 6, 5, 250);
    single(0, 3, 5, 10);
    single(0, 7, 5, 0);
    single(0, 0, 5, 0);

    // random mix over a few colliding words
    scenTag = "R11 random";
    for (int k = 0; k < 400; k++) begin
      beginCycle();
      for (int r = 0; r < NR; r++) begin
        if ($urandom_range(0, 2) != 0)
          setReq(r, $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 255));
      end
      endCycle();
    end

    scenTag = "R3 drain";
    beginCycle();
    endCycle();
    beginCycle();
    endCycle();
    finishRun();
  end

endmodule